// File: doc/BRIEF.md
# Cartridge PRG Bank Controller

This block sits on the CPU side of a game cartridge with an 8-bit data bus and a 16-bit address bus. CPU writes anywhere in $8000–$FFFF are decoded into a small set of banking registers. A static selector input picks the two low address lines that form the two-bit register sub-index, and which of those two lines is the low bit. The CPU space $8000–$FFFF is split into four 8 KB windows. Each window is translated into a ROM address made of a bank number and a 13-bit offset.

Two windows can be switched by software. The window at $A000 always follows its own register. A mode bit decides whether the window at $8000 or the one at $C000 follows the swappable register. Whichever of the two is not switchable shows the second-last bank. The window at $E000 always shows the last bank. The block also decodes an optional 8 KB work RAM at $6000–$7FFF.

Top module: `prg_bank_ctrl`

## Requirements
- R1: After reset, both bank registers and the mode bit are 0. $8000 and $A000 therefore map to bank 0, and $C000 maps to bank BANK_COUNT-2.
- R2: The sub-index is {high line, low line}. The line pair for each `line_sel` code is: 0 → A2,A1; 1 → A0,A1; 2 → A7,A6; 3 → A2,A3; 4 → A3,A2; 5 → A1,A0. In each pair the high line is listed first. Codes 6 and 7 decode like code 0.
- R3: A write to any address with A15..A12 = 4'h8 loads data bits 4..0 into the swappable bank register. The sub-index has no effect on this.
- R4: A write with A15..A12 = 4'hA loads data bits 4..0 into the $A000 bank register, for any sub-index.
- R5: A write with A15..A12 = 4'h9 and sub-index 2 or 3 loads data bit 1 into the mode bit. A write to group 9 with sub-index 0 or 1 leaves the mode bit unchanged.
- R6: With the mode bit at 0, window $8000 uses the swappable register and window $C000 shows bank BANK_COUNT-2.
- R7: With the mode bit at 1, window $8000 shows bank BANK_COUNT-2 and window $C000 uses the swappable register.
- R8: Window $E000 always shows bank BANK_COUNT-1, and window $A000 always uses its own register.
- R9: For addresses with A15 = 1, `rom_cs` is 1 and `prg_addr` = {bank, A12..A0}, with bank numbers masked to log2(BANK_COUNT) bits. For addresses with A15 = 0, `rom_cs` is 0.
- R10: `ram_cs` is 1 exactly when the address is in $6000–$7FFF and RAM_BYTES is nonzero. It never rises together with `rom_cs`.
- R11: A cycle with `cpu_wr` low, or with an address below $8000, changes no register. Writes to groups B–F change no PRG mapping.
- R12: A write is captured on the rising clock edge. Its effect is visible on `prg_addr` from that edge on, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sel | input | 3 | Static choice of the register-select address lines |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| prg_addr | output | BANK_W+13 | ROM address (bank, offset) |
| rom_cs | output | 1 | ROM select for $8000–$FFFF |
| ram_cs | output | 1 | Work RAM select for $6000–$7FFF |

## Verification
The assertions assume that `line_sel` changes only between writes, and that `cpu_addr`, `cpu_data` and `cpu_wr` are steady across each rising edge. The stimulus meets this by driving all inputs on the falling edge. It changes the line selector only during cycles with no write, and it uses only selector codes 0 to 5. Random phases spread writes over all sixteen address groups, so that writes to groups that must be ignored fall between the meaningful ones.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;
  localparam int OFF_W = 13;
  localparam int REG_W = 5;

  typedef enum logic [2:0] {
    SEL_A2_A1 = 3'd0,
    SEL_A0_A1 = 3'd1,
    SEL_A7_A6 = 3'd2,
    SEL_A2_A3 = 3'd3,
    SEL_A3_A2 = 3'd4,
    SEL_A1_A0 = 3'd5
  } line_pair_e;

  typedef enum logic [1:0] {
    WIN_8000 = 2'd0,
    WIN_A000 = 2'd1,
    WIN_C000 = 2'd2,
    WIN_E000 = 2'd3
  } window_e;

  // returns {high line, low line}
  function automatic logic [1:0] pick_sub(input logic [2:0] sel, input logic [7:0] a);
    case (sel)
      SEL_A0_A1: return {a[0], a[1]};
      SEL_A7_A6: return {a[7], a[6]};
      SEL_A2_A3: return {a[2], a[3]};
      SEL_A3_A2: return {a[3], a[2]};
      SEL_A1_A0: return {a[1], a[0]};
      default:   return {a[2], a[1]};
    endcase
  endfunction

  // bank that sits 'back' banks below the top of the ROM, masked to the bank width
  function automatic logic [31:0] top_bank(input int count, input int back, input int bw);
    logic [31:0] mask;
    mask = (32'd1 << bw) - 32'd1;
    return 32'(count - back) & mask;
  endfunction
endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
  import prg_bank_pkg::*;
(
  input  logic [2:0]  line_sel,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_wr,
  output logic [1:0]  sub_idx,
  output logic        wr_hit,
  output logic        ld_swap,
  output logic        ld_mid,
  output logic        ld_mode
);
  logic [3:0] group;

  always_comb begin
    group   = cpu_addr[15:12];
    sub_idx = pick_sub(line_sel, cpu_addr[7:0]);
    wr_hit  = cpu_wr & cpu_addr[15];
    ld_swap = wr_hit && (group == 4'h8);
    ld_mid  = wr_hit && (group == 4'hA);
    ld_mode = wr_hit && (group == 4'h9) && sub_idx[1];
  end
endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cpu_data,
  input  logic             ld_swap,
  input  logic             ld_mid,
  input  logic             ld_mode,
  output logic [REG_W-1:0] swap_bank,
  output logic [REG_W-1:0] mid_bank,
  output logic             mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_bank <= '0;
      mid_bank  <= '0;
      mode      <= 1'b0;
    end else begin
      if (ld_swap) swap_bank <= cpu_data[REG_W-1:0];
      if (ld_mid)  mid_bank  <= cpu_data[REG_W-1:0];
      if (ld_mode) mode      <= cpu_data[1];
    end
  end
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
  import prg_bank_pkg::*;
#(
  parameter int BANK_COUNT = 32,
  parameter int BANK_W     = 5
) (
  input  logic [15:0]             cpu_addr,
  input  logic [REG_W-1:0]        swap_bank,
  input  logic [REG_W-1:0]        mid_bank,
  input  logic                    mode,
  output logic [1:0]              win,
  output logic [BANK_W+OFF_W-1:0] prg_addr
);
  localparam logic [31:0] SECOND_W = top_bank(BANK_COUNT, 2, BANK_W);
  localparam logic [31:0] LAST_W   = top_bank(BANK_COUNT, 1, BANK_W);
  localparam logic [BANK_W-1:0] SECOND = SECOND_W[BANK_W-1:0];
  localparam logic [BANK_W-1:0] LAST   = LAST_W[BANK_W-1:0];

  logic [BANK_W-1:0] bank;
  logic [BANK_W-1:0] sw_b;
  logic [BANK_W-1:0] mid_b;

  always_comb begin
    sw_b  = swap_bank[BANK_W-1:0];
    mid_b = mid_bank[BANK_W-1:0];
    win   = cpu_addr[14:13];
    case (window_e'(win))
      WIN_8000: bank = mode ? SECOND : sw_b;
      WIN_A000: bank = mid_b;
      WIN_C000: bank = mode ? sw_b : SECOND;
      default:  bank = LAST;
    endcase
    prg_addr = {bank, cpu_addr[OFF_W-1:0]};
  end
endmodule

// File: rtl/prg_bank_ctrl.sv
module prg_bank_ctrl
  import prg_bank_pkg::*;
#(
  parameter int BANK_COUNT = 32,
  parameter int RAM_BYTES  = 8192,
  parameter int BANK_W     = $clog2(BANK_COUNT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              line_sel,
  input  logic [15:0]             cpu_addr,
  input  logic [7:0]              cpu_data,
  input  logic                    cpu_wr,
  output logic [BANK_W+OFF_W-1:0] prg_addr,
  output logic                    rom_cs,
  output logic                    ram_cs
);
  logic [1:0]       sub_idx;
  logic             wr_hit;
  logic             ld_swap;
  logic             ld_mid;
  logic             ld_mode;
  logic [REG_W-1:0] swap_bank_q;
  logic [REG_W-1:0] mid_bank_q;
  logic             mode_q;
  logic [1:0]       win;

  prg_wr_decode u_dec (
    .line_sel(line_sel), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .sub_idx(sub_idx), .wr_hit(wr_hit),
    .ld_swap(ld_swap), .ld_mid(ld_mid), .ld_mode(ld_mode)
  );

  prg_bank_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_data(cpu_data),
    .ld_swap(ld_swap), .ld_mid(ld_mid), .ld_mode(ld_mode),
    .swap_bank(swap_bank_q), .mid_bank(mid_bank_q), .mode(mode_q)
  );

  prg_window_map #(.BANK_COUNT(BANK_COUNT), .BANK_W(BANK_W)) u_map (
    .cpu_addr(cpu_addr), .swap_bank(swap_bank_q), .mid_bank(mid_bank_q),
    .mode(mode_q), .win(win), .prg_addr(prg_addr)
  );

  assign rom_cs = cpu_addr[15];

  generate
    if (RAM_BYTES > 0) begin : g_ram
      assign ram_cs = (cpu_addr[15:13] == 3'b011);
    end else begin : g_no_ram
      assign ram_cs = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/prg_bank_checks.sv
module prg_bank_checks
  import prg_bank_pkg::*;
#(
  parameter int BANK_COUNT = 32,
  parameter int BANK_W     = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [15:0]             cpu_addr,
  input logic [7:0]              cpu_data,
  input logic                    cpu_wr,
  input logic [1:0]              sub_idx,
  input logic [REG_W-1:0]        swap_bank,
  input logic [REG_W-1:0]        mid_bank,
  input logic                    mode,
  input logic [BANK_W+OFF_W-1:0] prg_addr,
  input logic                    rom_cs,
  input logic                    ram_cs
);
  localparam logic [31:0] SEC_W  = top_bank(BANK_COUNT, 2, BANK_W);
  localparam logic [31:0] LST_W  = top_bank(BANK_COUNT, 1, BANK_W);

  assert_swap_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'h8) |=> swap_bank == $past(cpu_data[REG_W-1:0]));

  assert_mid_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'hA) |=> mid_bank == $past(cpu_data[REG_W-1:0]));

  assert_mode_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'h9 && sub_idx[1]) |=> mode == $past(cpu_data[1]));

  assert_mode_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'h9 && !sub_idx[1]) |=> $stable(mode));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[15]) |=> ($stable(swap_bank) && $stable(mid_bank) && $stable(mode)));

  assert_fixed_c000_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && cpu_addr[15:13] == 3'b110) |-> prg_addr[OFF_W +: BANK_W] == SEC_W[BANK_W-1:0]);

  assert_fixed_8000_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && cpu_addr[15:13] == 3'b100) |-> prg_addr[OFF_W +: BANK_W] == SEC_W[BANK_W-1:0]);

  assert_last_e000_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> prg_addr[OFF_W +: BANK_W] == LST_W[BANK_W-1:0]);

  assert_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> prg_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rom_cs, ram_cs}) <= 1);
endmodule

bind prg_bank_ctrl prg_bank_checks #(.BANK_COUNT(BANK_COUNT), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
  .sub_idx(sub_idx), .swap_bank(swap_bank_q), .mid_bank(mid_bank_q), .mode(mode_q),
  .prg_addr(prg_addr), .rom_cs(rom_cs), .ram_cs(ram_cs)
);

// File: tb/prg_bank_ctrl_test.sv
module prg_bank_ctrl_test;
  localparam int NB = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  line_sel = 3'd0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [17:0] prg_addr;
  logic        rom_cs;
  logic        ram_cs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_swap = 0, m_mid = 0, m_mode = 0;
  int lo_ln[6] = '{1, 1, 6, 3, 2, 0};
  int hi_ln[6] = '{2, 0, 7, 2, 3, 1};

  prg_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .line_sel(line_sel), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cpu_wr(cpu_wr), .prg_addr(prg_addr),
    .rom_cs(rom_cs), .ram_cs(ram_cs)
  );

  always #5 clk = ~clk;

  function automatic int model_sub(int v, int a);
    return ((a >> lo_ln[v]) & 1) | (((a >> hi_ln[v]) & 1) << 1);
  endfunction

  function automatic int model_bank(int a);
    int w;
    w = (a / 8192) % 4;
    if (w == 0) return (m_mode != 0) ? NB - 2 : m_swap;
    if (w == 1) return m_mid;
    if (w == 2) return (m_mode != 0) ? m_swap : NB - 2;
    return NB - 1;
  endfunction

  function automatic int mk_addr(int grp, int sub, int v);
    int a;
    a = grp * 4096;
    if ((sub & 1) != 0) a = a | (1 << lo_ln[v]);
    if ((sub & 2) != 0) a = a | (1 << hi_ln[v]);
    return a;
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // model update on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_swap = 0; m_mid = 0; m_mode = 0;
    end else if (cpu_wr && cpu_addr >= 16'h8000) begin
      int g;
      g = int'(cpu_addr) / 4096;
      if (g == 8) m_swap = cpu_data & 31;
      if (g == 10) m_mid = cpu_data & 31;
      if (g == 9 && model_sub(int'(line_sel), int'(cpu_addr)) >= 2) m_mode = (cpu_data >> 1) & 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      int a;
      a = int'(cpu_addr);
      check("R9 rom_cs", int'(rom_cs), (a >= 32768) ? 1 : 0);
      check("R10 ram_cs", int'(ram_cs), (a >= 24576 && a < 32768) ? 1 : 0);
      if (a >= 32768)
        check("R9 prg_addr", int'(prg_addr), model_bank(a) * 8192 + (a % 8192));
    end
  end

  task automatic wr_reg(int grp, int sub, int d);
    @(negedge clk);
    cpu_addr = 16'(mk_addr(grp, sub, int'(line_sel)));
    cpu_data = 8'(d);
    cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(int a);
    @(negedge clk);
    cpu_wr = 1'b0;
    cpu_addr = 16'(a);
    #3;
  endtask

  function automatic int bank_of();
    return int'(prg_addr) / 8192;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(16'h8123); check("R1 8000 bank", bank_of(), 0);
    rd(16'hA000); check("R1 A000 bank", bank_of(), 0);
    rd(16'hC000); check("R1 C000 bank", bank_of(), NB - 2);

    for (int v = 0; v < 6; v++) begin
      @(negedge clk); line_sel = 3'(v);
      for (int s = 0; s < 4; s++) begin
        wr_reg(8, s, 3 * s + v + 1);
        rd(16'h8000); check("R3 R2 swap load", bank_of(), 3 * s + v + 1);
        wr_reg(10, s, 200 + 7 * s + v);
        rd(16'hA345); check("R4 mid load masked", bank_of(), (200 + 7 * s + v) & 31);
      end
      wr_reg(9, 1, 8'h02);
      rd(16'hC000); check("R5 mode kept on sub 1", bank_of(), NB - 2);
      wr_reg(9, 2, 8'h02);
      rd(16'h8000); check("R7 8000 fixed", bank_of(), NB - 2);
      rd(16'hC777); check("R7 C000 swap", bank_of(), 3 * 3 + v + 1);
      rd(16'hE000); check("R8 last", bank_of(), NB - 1);
      wr_reg(9, 3, 8'h00);
      rd(16'hC000); check("R6 C000 fixed", bank_of(), NB - 2);
      rd(16'h8000); check("R6 8000 swap", bank_of(), 3 * 3 + v + 1);
    end

    // R11: strobe low, low addresses, and other groups
    @(negedge clk); cpu_addr = 16'h8000; cpu_data = 8'h1F; cpu_wr = 1'b0;
    rd(16'h8000); check("R11 no strobe", bank_of(), 3 * 3 + 5 + 1);
    @(negedge clk); cpu_addr = 16'h6000; cpu_data = 8'h07; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
    rd(16'h8000); check("R11 low address", bank_of(), 3 * 3 + 5 + 1);
    wr_reg(11, 2, 8'h0E); wr_reg(15, 3, 8'h0E);
    rd(16'hA000); check("R11 other group", bank_of(), (200 + 21 + 5) & 31);

    // R12: before the edge the old bank is still shown
    @(negedge clk); cpu_addr = 16'h8000; cpu_data = 8'h04; cpu_wr = 1'b1;
    #3; check("R12 before edge", bank_of(), 3 * 3 + 5 + 1);
    @(negedge clk); #3; check("R12 after edge", bank_of(), 4);
    cpu_wr = 1'b0;

    // R10: work RAM decode
    rd(16'h6123); check("R10 ram in range", int'(ram_cs), 1);
    rd(16'h5FFF); check("R10 ram below", int'(ram_cs), 0);
    rd(16'hF000); check("R9 rom_cs high", int'(rom_cs), 1);

    // random traffic, compared every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i % 250 == 0) begin
        cpu_wr = 1'b0;
        line_sel = 3'($urandom_range(0, 5));
      end else begin
        cpu_addr = 16'($urandom);
        cpu_data = 8'($urandom);
        cpu_wr = ($urandom_range(0, 2) == 0);
      end
    end
    @(negedge clk); cpu_wr = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule